// File: doc/BRIEF.md
# Sequential Shift-Add Unsigned Multiplier

This block multiplies two unsigned operands of `W` bits (32 by default) and returns the full `2W`-bit product. It uses a single `W`-bit adder and a `2W`-bit product register. The operand that acts as the multiplier is held in the lower half of that register, so there is no separate register for it. In each step the block looks at bit 0 of the product register. When that bit is set, it adds the multiplicand into the upper half. The whole register, together with the adder's carry, then moves one place to the right.

A one-cycle `start` while the block is idle captures both operands. The block then runs `W` iterations at one per clock, drops `busy` and pulses `done` for one cycle. From that cycle on, `product` holds the result and keeps it until the next accepted `start`. The block does not listen to `start` while it is busy.

Top module: `shift_add_mul`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `busy` = 0, `done` = 0 and `product` = 0.
- R2: A `start` sampled high while `busy` is low captures `mcand` and `mplier`. `busy` is high from the next cycle.
- R3: If `start` is accepted at clock edge k, then `done` is high for exactly one cycle after edge k+W. In that same cycle `busy` is low.
- R4: The result is the exact unsigned product `mcand * mplier` over `2W` bits, with no carry lost. This includes the all-ones operands.
- R5: A `start` sampled while `busy` is high has no effect. The running multiply completes with its original operands, and no extra `done` follows.
- R6: After `done`, `product` stays unchanged until the next accepted `start`.
- R7: A zero in either operand gives a zero product.
- R8: With W = 5, the operands 17 and 19 give 323.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a multiply; taken only when idle |
| mcand | input | W | Multiplicand operand |
| mplier | input | W | Multiplier operand |
| busy | output | 1 | High while iterations run |
| done | output | 1 | One-cycle pulse when `product` is valid |
| product | output | 2W | Product register contents |

## Verification
The bench builds two copies of the block.

- **Default width, W = 32.** This copy covers:
  - all-ones operands, which push a carry out of the adder on almost every step;
  - zero operands;
  - mixed bit patterns;
  - exact latency of W+1 cycles from the `start` cycle;
  - a `start` pulse sent into the middle of a run.
- **Small width, W = 5.** This copy is fed every one of the 1024 operand pairs. That makes every add and no-add sequence and every carry pattern reachable, including the 17 × 19 case.

// File: rtl/shift_add_mul.sv
module shift_add_mul #(
  parameter int W = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [W-1:0]   mcand,
  input  logic [W-1:0]   mplier,
  output logic           busy,
  output logic           done,
  output logic [2*W-1:0] product
);
  localparam int CW = $clog2(W + 1);

  logic [W-1:0]   mcand_q;
  logic [2*W-1:0] prod_q;
  logic [CW-1:0]  step_q;
  logic           busy_q;
  logic           done_q;

  wire            take    = start && !busy_q;
  wire            last    = step_q == CW'(W - 1);
  wire [W-1:0]    addend  = prod_q[0] ? mcand_q : '0;
  wire [W:0]      sum     = {1'b0, prod_q[2*W-1:W]} + {1'b0, addend};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mcand_q <= '0;
      prod_q  <= '0;
      step_q  <= '0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (take) begin
        mcand_q <= mcand;
        prod_q  <= {{W{1'b0}}, mplier};
        step_q  <= '0;
        busy_q  <= 1'b1;
      end else if (busy_q) begin
        prod_q <= {sum, prod_q[W-1:1]};
        step_q <= step_q + 1'b1;
        if (last) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign busy    = busy_q;
  assign done    = done_q;
  assign product = prod_q;

  // R2
  busy_after_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  // R3
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R3
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  // R5
  operand_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(mcand_q));

  // R6
  product_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(product));
endmodule

// File: tb/shift_add_mul_tb.sv
module shift_add_mul_tb;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        st32 = 1'b0, st5 = 1'b0;
  logic [31:0] a32 = '0, b32 = '0;
  logic [4:0]  a5 = '0, b5 = '0;
  logic        busy32, done32, busy5, done5;
  logic [63:0] p32;
  logic [9:0]  p5;

  int checks = 0, failures = 0;
  logic [63:0] q32[$];
  logic [9:0]  q5[$];

  shift_add_mul #(.W(32)) u_dut (.clk(clk), .rst_n(rst_n), .start(st32),
    .mcand(a32), .mplier(b32), .busy(busy32), .done(done32), .product(p32));
  shift_add_mul #(.W(5)) u_dut_small (.clk(clk), .rst_n(rst_n), .start(st5),
    .mcand(a5), .mplier(b5), .busy(busy5), .done(done5), .product(p5));

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && done32) begin
      if (q32.size() == 0) check(1'b0, "R5 extra done", 64'd1, 64'd0);
      else begin
        logic [63:0] e;
        e = q32.pop_front();
        check(p32 == e, "R4 product", p32, e);
      end
    end
    if (rst_n && done5) begin
      if (q5.size() == 0) check(1'b0, "R5 extra done small", 64'd1, 64'd0);
      else begin
        logic [9:0] e;
        e = q5.pop_front();
        check(p5 == e, "R4 product small", 64'(p5), 64'(e));
      end
    end
  end

  task automatic run32(input logic [31:0] a, input logic [31:0] b, input int poke);
    int lat;
    logic [63:0] hold;
    @(negedge clk);
    while (busy32) @(negedge clk);
    a32 = a; b32 = b; st32 = 1'b1;
    q32.push_back(64'(a) * 64'(b));
    @(negedge clk);
    st32 = 1'b0;
    lat = 1;
    check(busy32 === 1'b1, "R2 busy after start", 64'(busy32), 64'd1);
    while (!done32 && lat < 200) begin
      if (lat == poke) begin
        a32 = ~a; b32 = ~b; st32 = 1'b1;
      end else st32 = 1'b0;
      @(negedge clk);
      lat++;
    end
    st32 = 1'b0;
    check(lat == 33, "R3 latency", 64'(lat), 64'd33);
    check(busy32 === 1'b0, "R3 busy low at done", 64'(busy32), 64'd0);
    hold = p32;
    @(negedge clk);
    check(done32 === 1'b0, "R3 done one cycle", 64'(done32), 64'd0);
    repeat (3) @(negedge clk);
    check(p32 == hold, "R6 product held", p32, hold);
  endtask

  task automatic run5(input logic [4:0] a, input logic [4:0] b);
    @(negedge clk);
    while (busy5) @(negedge clk);
    a5 = a; b5 = b; st5 = 1'b1;
    q5.push_back(10'(a) * 10'(b));
    @(negedge clk);
    st5 = 1'b0;
    while (!done5) @(negedge clk);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        check(busy32 === 1'b0 && done32 === 1'b0 && p32 === '0, "R1 reset state", p32, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy32 === 1'b0 && done32 === 1'b0 && p32 === '0, "R1 after reset", p32, 64'd0);
        run32(32'd17, 32'd19, 0);
        run32(32'hFFFF_FFFF, 32'hFFFF_FFFF, 0);
        run32(32'h0, 32'hDEAD_BEEF, 0);
        check(p32 == 64'd0, "R7 zero mcand", p32, 64'd0);
        run32(32'h1234_5678, 32'h0, 0);
        check(p32 == 64'd0, "R7 zero mplier", p32, 64'd0);
        run32(32'hA5A5_0F0F, 32'h8000_0001, 0);
        run32(32'h8000_0000, 32'hFFFF_FFFF, 0);
        run32(32'h0BAD_CAFE, 32'h1357_9BDF, 5);
        run32(32'hFFFF_0001, 32'h7FFF_FFFF, 20);
        check(q32.size() == 0, "R5 no pending result", 64'(q32.size()), 64'd0);
        run5(5'd17, 5'd19);
        @(negedge clk);
        check(p5 == 10'd323, "R8 17x19", 64'(p5), 64'd323);
        for (int i = 0; i < 32; i++)
          for (int j = 0; j < 32; j++)
            run5(5'(i), 5'(j));
        repeat (3) @(negedge clk);
        check(q5.size() == 0, "R4 small all results seen", 64'(q5.size()), 64'd0);
      end
      begin
        repeat (150000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule